// File: doc/BRIEF.md
# Two-Level Hashed Page Table Walker

After a translation miss, this block resolves a virtual page to a physical page number. It searches a hashed page table in an attached memory. The request carries a 24-bit segment identifier and a 16-bit page index. The table is made of buckets of eight entries, and each entry occupies one memory word. The walker reads the bucket chosen by a primary hash, slot by slot. If nothing matches there, it reads an overflow bucket chosen by a secondary hash. It reports a fault only when both buckets miss, so that software can handle the miss.

Lookups enter through a valid/ready request handshake and leave through a valid/ready response. The response carries either the 20-bit physical page number or a fault flag. Memory is reached through a read port with a fixed latency and a single-word write port. The write port is used only to set the referenced bit of the matched entry, and that write happens before the response is raised. The table base address and the bucket mask are configuration inputs. The walker latches both when it accepts a request.

The controller has six states, each with named transitions:
- ST_IDLE goes to ST_PRIMARY when a request is accepted.
- ST_PRIMARY goes to ST_WRBACK on a match. It goes to ST_SECONDARY when slot 7 misses.
- ST_SECONDARY goes to ST_WRBACK on a match. It goes to ST_FAULT when slot 7 misses.
- ST_WRBACK goes to ST_DONE after its single write cycle.
- ST_DONE and ST_FAULT each return to ST_IDLE when the response handshake completes.

Top module: `hpt_walker`

## Requirements
- R1: After reset the walker is in ST_IDLE. It holds req_ready_o high and resp_valid_o low, and it drives no memory read or write until a request arrives.
- R2: The primary bucket index is (segment[18:0] XOR zero-extended page index) AND the bucket mask. Slot k of bucket b is at word address base + 8*b + k. Read data is used exactly RD_LAT cycles after the cycle in which the read enable is high.
- R3: An entry word is laid out as follows:
  - bit 52: valid
  - bit 51: hash select (0 = primary probe, 1 = secondary probe)
  - bit 50: referenced
  - bits 49:26: segment identifier
  - bits 25:20: page index bits 15:10
  - bits 19:0: physical page number

  An entry matches only when four conditions all hold: it is valid, its hash select equals the current probe, its segment is equal to the request's, and its tag field is equal to the request's.
- R4: Within a bucket, slots are read in order from 0 to 7, one read per slot. The first matching slot ends the search, so a hit in primary slot s costs s+1 reads.
- R5: After eight primary misses, the walker reads the overflow bucket (NOT primary index) AND mask, slots 0 to 7. A hit in overflow slot s costs 9+s reads in total. A match in the primary bucket always wins over one in the overflow bucket.
- R6: When both buckets miss, the response has resp_fault_o = 1 and resp_ppn_o = 0. Exactly 16 reads occur, and the walker writes nothing to memory.
- R7: On a hit, the response has resp_fault_o = 0 and resp_ppn_o equal to the matched entry's physical page number.
- R8: Before a hit response, the walker makes exactly one write, to the matched entry's address. The written word is the entry as read, with bit 50 set.
- R9: The walker holds the response and its payload stable until resp_ready_i is high. req_ready_o stays low from acceptance until the response handshake completes, so a request offered in that window is not taken.
- R10: The base and mask are sampled when a request is accepted. Changing them during a walk has no effect on that walk's addresses or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base_i | input | ADDR_W | Word address of bucket 0 |
| tbl_mask_i | input | 19 | Bucket index mask (bucket count minus one) |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Walker can accept a request |
| req_vsid_i | input | 24 | Segment identifier of the missing page |
| req_pidx_i | input | 16 | Page index of the missing page |
| resp_valid_o | output | 1 | Result valid |
| resp_ready_i | input | 1 | Result consumed |
| resp_fault_o | output | 1 | Both buckets missed |
| resp_ppn_o | output | 20 | Physical page number on a hit |
| mem_rd_en_o | output | 1 | Table read request |
| mem_rd_addr_o | output | ADDR_W | Table read word address |
| mem_rd_data_i | input | 53 | Entry word, RD_LAT cycles after the read |
| mem_wr_en_o | output | 1 | Referenced-bit write-back enable |
| mem_wr_addr_o | output | ADDR_W | Write-back word address |
| mem_wr_data_o | output | 53 | Entry word with referenced bit set |

## Verification
The embedded properties check the handshake and write-back rules on every cycle:
- the response and its payload stay stable while they wait for resp_ready_i;
- a hit response always follows exactly one write, and that write has the referenced bit set;
- a fault response never follows a write;
- reads, writes and responses never overlap;
- the two hash indices differ whenever the mask is non-zero.

Only the bench's scenarios can show whether the right entry was found at the right addresses. A sweep places one entry in every slot of both buckets for several request patterns. It compares the recorded read-address sequence, the returned page number and the written-back word against values derived from the hash formula. Targeted cases cover the remaining rules: hash-select aliasing, invalid entries, tag mismatches, first-match priority, primary-over-overflow priority, a held response, and configuration changes in the middle of a walk.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
    localparam int VSID_W = 24;
    localparam int PIDX_W = 16;
    localparam int PPN_W  = 20;
    localparam int API_W  = 6;
    localparam int HASH_W = 19;
    localparam int SLOTS  = 8;
    localparam int SLOT_W = $clog2(SLOTS);

    typedef struct packed {
        logic              valid;
        logic              hsel;
        logic              refd;
        logic [VSID_W-1:0] vsid;
        logic [API_W-1:0]  api;
        logic [PPN_W-1:0]  ppn;
    } pte_t;

    localparam int PTE_W = $bits(pte_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRIMARY,
        ST_SECONDARY,
        ST_WRBACK,
        ST_DONE,
        ST_FAULT
    } walk_state_e;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
    import hpt_pkg::*;
(
    input  logic [HASH_W-1:0] vsid_lo_i,
    input  logic [PIDX_W-1:0] pidx_i,
    input  logic [HASH_W-1:0] mask_i,
    output logic [HASH_W-1:0] pri_idx_o,
    output logic [HASH_W-1:0] sec_idx_o
);
    localparam int PAD_W = HASH_W - PIDX_W;

    logic [HASH_W-1:0] raw_hash;

    generate
        if (PAD_W > 0) begin : g_pad
            assign raw_hash = vsid_lo_i ^ {{PAD_W{1'b0}}, pidx_i};
        end else begin : g_nopad
            assign raw_hash = vsid_lo_i ^ pidx_i[HASH_W-1:0];
        end
    endgenerate

    assign pri_idx_o = raw_hash & mask_i;
    assign sec_idx_o = ~pri_idx_o & mask_i;
endmodule

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen
    import hpt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [HASH_W-1:0] bucket_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int OFF_W = HASH_W + SLOT_W;

    logic [OFF_W-1:0] offset;

    assign offset = {bucket_i, slot_i};
    assign addr_o = base_i + ADDR_W'(offset);
endmodule

// File: rtl/hpt_match.sv
module hpt_match
    import hpt_pkg::*;
(
    input  logic              ent_valid_i,
    input  logic              ent_hsel_i,
    input  logic [VSID_W-1:0] ent_vsid_i,
    input  logic [API_W-1:0]  ent_api_i,
    input  logic [VSID_W-1:0] req_vsid_i,
    input  logic [API_W-1:0]  req_api_i,
    input  logic              probe_sec_i,
    output logic              hit_o
);
    logic tag_eq;

    assign tag_eq = (ent_vsid_i == req_vsid_i) && (ent_api_i == req_api_i);
    assign hit_o  = ent_valid_i && (ent_hsel_i == probe_sec_i) && tag_eq;
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] tbl_base_i,
    input  logic [18:0]       tbl_mask_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [23:0]       req_vsid_i,
    input  logic [15:0]       req_pidx_i,
    output logic              resp_valid_o,
    input  logic              resp_ready_i,
    output logic              resp_fault_o,
    output logic [19:0]       resp_ppn_o,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_rd_addr_o,
    input  logic [52:0]       mem_rd_data_i,
    output logic              mem_wr_en_o,
    output logic [ADDR_W-1:0] mem_wr_addr_o,
    output logic [52:0]       mem_wr_data_o
);
    localparam int LAT_W = $clog2(RD_LAT + 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    walk_state_e       state_q, state_d;
    logic [VSID_W-1:0] vsid_q;
    logic [PIDX_W-1:0] pidx_q;
    logic [ADDR_W-1:0] base_q;
    logic [HASH_W-1:0] mask_q;
    logic [SLOT_W-1:0] slot_q;
    logic              waiting_q;
    logic [LAT_W-1:0]  wcnt_q;
    logic [ADDR_W-1:0] hit_addr_q;
    pte_t              hit_pte_q;

    logic [HASH_W-1:0] pri_idx, sec_idx, cur_idx;
    logic [ADDR_W-1:0] probe_addr;
    logic              probing, probe_sec, data_ok, slot_hit;
    pte_t              rd_pte, wb_pte;

    assign rd_pte    = pte_t'(mem_rd_data_i);
    assign probing   = (state_q == ST_PRIMARY) || (state_q == ST_SECONDARY);
    assign probe_sec = (state_q == ST_SECONDARY);
    assign data_ok   = probing && waiting_q && (wcnt_q == LAT_W'(1));
    assign cur_idx   = probe_sec ? sec_idx : pri_idx;

    hpt_hash u_hash (
        .vsid_lo_i (vsid_q[HASH_W-1:0]),
        .pidx_i    (pidx_q),
        .mask_i    (mask_q),
        .pri_idx_o (pri_idx),
        .sec_idx_o (sec_idx)
    );

    hpt_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .base_i   (base_q),
        .bucket_i (cur_idx),
        .slot_i   (slot_q),
        .addr_o   (probe_addr)
    );

    hpt_match u_match (
        .ent_valid_i (rd_pte.valid),
        .ent_hsel_i  (rd_pte.hsel),
        .ent_vsid_i  (rd_pte.vsid),
        .ent_api_i   (rd_pte.api),
        .req_vsid_i  (vsid_q),
        .req_api_i   (pidx_q[PIDX_W-1 -: API_W]),
        .probe_sec_i (probe_sec),
        .hit_o       (slot_hit)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid_i) state_d = ST_PRIMARY;
            end
            ST_PRIMARY: begin
                if (data_ok) begin
                    if (slot_hit)                 state_d = ST_WRBACK;
                    else if (slot_q == LAST_SLOT) state_d = ST_SECONDARY;
                end
            end
            ST_SECONDARY: begin
                if (data_ok) begin
                    if (slot_hit)                 state_d = ST_WRBACK;
                    else if (slot_q == LAST_SLOT) state_d = ST_FAULT;
                end
            end
            ST_WRBACK: state_d = ST_DONE;
            ST_DONE, ST_FAULT: begin
                if (resp_ready_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Walk datapath: request capture, slot stepping, latency count, hit capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsid_q     <= '0;
            pidx_q     <= '0;
            base_q     <= '0;
            mask_q     <= '0;
            slot_q     <= '0;
            waiting_q  <= 1'b0;
            wcnt_q     <= '0;
            hit_addr_q <= '0;
            hit_pte_q  <= '0;
        end else if (state_q == ST_IDLE) begin
            if (req_valid_i) begin
                vsid_q    <= req_vsid_i;
                pidx_q    <= req_pidx_i;
                base_q    <= tbl_base_i;
                mask_q    <= tbl_mask_i;
                slot_q    <= '0;
                waiting_q <= 1'b0;
                hit_pte_q <= '0;
            end
        end else if (probing) begin
            if (!waiting_q) begin
                waiting_q <= 1'b1;
                wcnt_q    <= LAT_W'(RD_LAT);
            end else if (!data_ok) begin
                wcnt_q <= wcnt_q - LAT_W'(1);
            end else begin
                waiting_q <= 1'b0;
                if (slot_hit) begin
                    hit_addr_q <= probe_addr;
                    hit_pte_q  <= rd_pte;
                end else begin
                    slot_q <= slot_q + SLOT_W'(1);
                end
            end
        end
    end

    always_comb begin
        wb_pte      = hit_pte_q;
        wb_pte.refd = 1'b1;
    end

    // Outputs
    always_comb begin
        req_ready_o   = (state_q == ST_IDLE);
        resp_valid_o  = (state_q == ST_DONE) || (state_q == ST_FAULT);
        resp_fault_o  = (state_q == ST_FAULT);
        resp_ppn_o    = (state_q == ST_DONE) ? hit_pte_q.ppn : '0;
        mem_rd_en_o   = probing && !waiting_q;
        mem_rd_addr_o = probe_addr;
        mem_wr_en_o   = (state_q == ST_WRBACK);
        mem_wr_addr_o = hit_addr_q;
        mem_wr_data_o = wb_pte;
    end

    // R9
    resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o && !resp_ready_i |=>
            resp_valid_o && $stable(resp_fault_o) && $stable(resp_ppn_o));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> !resp_valid_o && !mem_rd_en_o && !mem_wr_en_o);

    // R4
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_en_o, mem_wr_en_o, resp_valid_o}));

    // R8
    wb_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en_o |=> resp_valid_o && !resp_fault_o);

    // R8
    wb_ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en_o |-> mem_wr_data_o[50]);

    // R7
    hit_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_valid_o) && !resp_fault_o |-> $past(mem_wr_en_o));

    // R6
    fault_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_valid_o) && resp_fault_o |-> !$past(mem_wr_en_o));

    // R5
    buckets_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        probing && (mask_q != '0) |-> pri_idx != sec_idx);
endmodule

// File: tb/hpt_walker_bench.sv
module hpt_walker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int RD_LAT     = 2;
    localparam logic [15:0] BASE = 16'h0040;
    localparam logic [18:0] MASK = 19'h7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] tbl_base = BASE;
    logic [18:0]       tbl_mask = MASK;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [23:0]       req_vsid = '0;
    logic [15:0]       req_pidx = '0;
    logic              resp_valid;
    logic              resp_ready = 1'b0;
    logic              resp_fault;
    logic [19:0]       resp_ppn;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [52:0]       rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [52:0]       wr_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    hpt_walker #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_hpt_walker (
        .clk(clk), .rst_n(rst_n), .tbl_base_i(tbl_base), .tbl_mask_i(tbl_mask),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_vsid_i(req_vsid), .req_pidx_i(req_pidx),
        .resp_valid_o(resp_valid), .resp_ready_i(resp_ready),
        .resp_fault_o(resp_fault), .resp_ppn_o(resp_ppn),
        .mem_rd_en_o(rd_en), .mem_rd_addr_o(rd_addr), .mem_rd_data_i(rd_data),
        .mem_wr_en_o(wr_en), .mem_wr_addr_o(wr_addr), .mem_wr_data_o(wr_data)
    );

    // Memory model: requests captured mid-cycle, applied at the next edge
    logic [52:0]       mem [256];
    logic [52:0]       pipe [RD_LAT];
    logic              rq_en = 1'b0, wq_en = 1'b0;
    logic [ADDR_W-1:0] rq_addr = '0, wq_addr = '0;
    logic [52:0]       wq_data = '0;
    logic              ld_en = 1'b0, clr = 1'b0;
    logic [7:0]        ld_addr = '0;
    logic [52:0]       ld_data = '0;
    int                tot_rd = 0, tot_wr = 0;
    logic [ADDR_W-1:0] rec [64];

    always @(negedge clk) begin
        rq_en   <= rd_en;
        rq_addr <= rd_addr;
        wq_en   <= wr_en;
        wq_addr <= wr_addr;
        wq_data <= wr_data;
        if (rd_en) begin
            rec[tot_rd % 64] <= rd_addr;
            tot_rd <= tot_rd + 1;
        end
        if (wr_en) tot_wr <= tot_wr + 1;
    end

    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
        end
        if (ld_en) mem[ld_addr] <= ld_data;
        if (wq_en) mem[wq_addr[7:0]] <= wq_data;
        pipe[0] <= rq_en ? mem[rq_addr[7:0]] : '0;
        for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
    end
    assign rd_data = pipe[RD_LAT-1];

    int n_tests = 0, n_fail = 0, cycles = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [18:0] pri_b(input logic [23:0] v, input logic [15:0] p,
                                          input logic [18:0] m);
        return (v[18:0] ^ {3'b000, p}) & m;
    endfunction

    function automatic logic [15:0] slot_addr(input logic [18:0] b, input int s);
        return BASE + 16'(b) * 16'd8 + 16'(s);
    endfunction

    function automatic logic [52:0] mk_pte(input logic vld, input logic hs, input logic [23:0] v,
                                           input logic [5:0] api, input logic [19:0] ppn);
        return {vld, hs, 1'b0, v, api, ppn};
    endfunction

    task automatic clear_mem();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic load(input logic [15:0] a, input logic [52:0] d);
        @(negedge clk); ld_en = 1'b1; ld_addr = a[7:0]; ld_data = d;
        @(negedge clk); ld_en = 1'b0;
    endtask

    logic        got_fault;
    logic [19:0] got_ppn;
    int          rd0, wr0, nrd, nwr;

    task automatic lookup(input logic [23:0] v, input logic [15:0] p, input int hold,
                          input bit chg_cfg);
        int cyc;
        @(negedge clk);
        rd0 = tot_rd; wr0 = tot_wr;
        req_vsid = v; req_pidx = p; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!resp_valid && cyc < 2000) begin
            if (chg_cfg && cyc == 3) begin
                tbl_base = 16'h0080; tbl_mask = 19'h3;
            end
            @(negedge clk);
            cyc++;
        end
        if (!resp_valid) chk("R9 response timeout", 0, 1);
        got_fault = resp_fault;
        got_ppn   = resp_ppn;
        for (int h = 0; h < hold; h++) begin
            req_valid = 1'b1; req_vsid = ~v;
            @(negedge clk);
            chk("R9 response held", {resp_valid, resp_fault, resp_ppn}, {1'b1, got_fault, got_ppn});
            chk("R9 busy not ready", req_ready, 0);
        end
        req_valid = 1'b0;
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
        tbl_base = BASE; tbl_mask = MASK;
        nrd = tot_rd - rd0;
        nwr = tot_wr - wr0;
    endtask

    // Compare recorded read addresses against the expected probe order
    task automatic chk_reads(input string req, input logic [18:0] pb, input int n);
        logic [18:0] sb;
        sb = ~pb & MASK;
        chk({req, " read count"}, nrd, n);
        for (int k = 0; k < n && k < 16; k++) begin
            chk({req, " read addr"}, rec[(rd0 + k) % 64],
                (k < 8) ? slot_addr(pb, k) : slot_addr(sb, k - 8));
        end
    endtask

    initial begin
        logic [23:0] v;
        logic [15:0] p;
        logic [18:0] pb, sb;
        logic [15:0] a;
        logic [52:0] e;
        logic [19:0] ppn;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 idle outputs", {req_ready, resp_valid, rd_en, wr_en}, 4'b1000);

        // R2 R4 R5 R7 R8 sweep: one entry in every slot of both buckets
        for (int vi = 0; vi < 3; vi++) begin
            for (int pi = 0; pi < 3; pi++) begin
                for (int sec = 0; sec < 2; sec++) begin
                    for (int s = 0; s < 8; s++) begin
                        v   = 24'h5A3C01 + 24'(vi * 24'h10F35);
                        p   = 16'h8C02 ^ 16'(pi * 16'h1403);
                        pb  = pri_b(v, p, MASK);
                        sb  = ~pb & MASK;
                        a   = slot_addr(sec ? sb : pb, s);
                        ppn = 20'(vi * 4096 + pi * 256 + sec * 16 + s + 1);
                        e   = mk_pte(1'b1, sec[0], v, p[15:10], ppn);
                        clear_mem();
                        load(a, e);
                        lookup(v, p, 0, 1'b0);
                        chk("R7 hit no fault", got_fault, 0);
                        chk("R7 hit ppn", got_ppn, ppn);
                        chk_reads(sec ? "R5" : "R4", pb, sec * 8 + s + 1);
                        chk("R8 one write", nwr, 1);
                        chk("R8 ref bit written", mem[a[7:0]], e | (53'd1 << 50));
                    end
                end
            end
        end

        v = 24'h123456; p = 16'hFFF1;
        pb = pri_b(v, p, MASK); sb = ~pb & MASK;

        // R6 empty table faults after 16 reads, no write
        clear_mem();
        lookup(v, p, 0, 1'b0);
        chk("R6 fault flag", got_fault, 1);
        chk("R6 fault ppn zero", got_ppn, 0);
        chk_reads("R6", pb, 16);
        chk("R6 no write", nwr, 0);

        // R3 hash-select mismatch in both buckets
        clear_mem();
        load(slot_addr(pb, 3), mk_pte(1'b1, 1'b1, v, p[15:10], 20'hAAAAA));
        load(slot_addr(sb, 3), mk_pte(1'b1, 1'b0, v, p[15:10], 20'hBBBBB));
        lookup(v, p, 0, 1'b0);
        chk("R3 hsel mismatch faults", got_fault, 1);
        chk("R3 hsel mismatch no write", nwr, 0);

        // R3 invalid entry and tag mismatches skipped
        clear_mem();
        load(slot_addr(pb, 0), mk_pte(1'b0, 1'b0, v, p[15:10], 20'h11111));
        load(slot_addr(pb, 1), mk_pte(1'b1, 1'b0, v, p[15:10] ^ 6'h20, 20'h22222));
        load(slot_addr(pb, 2), mk_pte(1'b1, 1'b0, v ^ 24'h800000, p[15:10], 20'h33333));
        load(slot_addr(pb, 4), mk_pte(1'b1, 1'b0, v, p[15:10], 20'h44444));
        lookup(v, p, 0, 1'b0);
        chk("R3 skip invalid/mismatch ppn", got_ppn, 20'h44444);
        chk("R3 skip reads", nrd, 5);
        chk("R3 invalid entry untouched", mem[slot_addr(pb, 0) % 256],
            mk_pte(1'b0, 1'b0, v, p[15:10], 20'h11111));

        // R4 first match wins within a bucket
        clear_mem();
        load(slot_addr(pb, 2), mk_pte(1'b1, 1'b0, v, p[15:10], 20'h0C0C2));
        load(slot_addr(pb, 5), mk_pte(1'b1, 1'b0, v, p[15:10], 20'h0C0C5));
        lookup(v, p, 0, 1'b0);
        chk("R4 first match ppn", got_ppn, 20'h0C0C2);
        chk("R4 first match reads", nrd, 3);

        // R5 primary beats overflow
        clear_mem();
        load(slot_addr(sb, 0), mk_pte(1'b1, 1'b1, v, p[15:10], 20'h5EC00));
        load(slot_addr(pb, 7), mk_pte(1'b1, 1'b0, v, p[15:10], 20'h9A170));
        lookup(v, p, 0, 1'b0);
        chk("R5 primary priority ppn", got_ppn, 20'h9A170);
        chk("R5 overflow untouched", mem[slot_addr(sb, 0) % 256],
            mk_pte(1'b1, 1'b1, v, p[15:10], 20'h5EC00));

        // R9 response held while not ready, busy request refused
        clear_mem();
        load(slot_addr(sb, 1), mk_pte(1'b1, 1'b1, v, p[15:10], 20'h76543));
        lookup(v, p, 5, 1'b0);
        chk("R9 held hit ppn", got_ppn, 20'h76543);
        @(negedge clk);
        chk("R9 ready after handshake", req_ready, 1);

        // R10 configuration change mid-walk has no effect
        clear_mem();
        load(slot_addr(sb, 4), mk_pte(1'b1, 1'b1, v, p[15:10], 20'h0F00D));
        lookup(v, p, 0, 1'b1);
        chk("R10 ppn unaffected", got_ppn, 20'h0F00D);
        chk_reads("R10", pb, 13);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule